// File: doc/BRIEF.md
# Saturating Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width that moves by one step on every clock edge where its count enable is high. A direction input picks the step: high adds one, low subtracts one. The counter never wraps. An up-step is refused once every bit of the count is 1, and a down-step is refused once every bit is 0. The refusal depends on the direction, so a counter held at one limit moves away from it as soon as the direction is reversed.

The block is meant for level trackers, credit counts and similar uses where a wrap-around would give a badly wrong value. The clock runs freely. Holding is done through a synchronous step-enable term, so no gated clock is formed. Two flags report the limits: one is high while the count is all ones, the other while it is all zeros.

Top module: `sat_updown_counter`

## Requirements
- R1: A synchronous active-high reset sets the count to 0 on the next rising edge, even when count enable is high. After reset, the at-min flag is 1 and the at-max flag is 0.
- R2: While count enable is 0, the count keeps its value on every edge, whatever the direction input is.
- R3: With count enable 1, direction 1 (up) and a count below all-ones, the count rises by exactly one on the next edge.
- R4: With count enable 1, direction 0 (down) and a count above zero, the count falls by exactly one on the next edge.
- R5: With count enable 1 and direction up, a count at all-ones stays at all-ones and does not become 0.
- R6: With count enable 1 and direction down, a count at zero stays at zero and does not become all-ones.
- R7: A count held at all-ones becomes all-ones minus one on the first enabled edge after the direction changes to down.
- R8: A count held at zero becomes 1 on the first enabled edge after the direction changes to up.
- R9: The at-max flag is 1 exactly when every count bit is 1. The at-min flag is 1 exactly when every count bit is 0. Both are decoded from the current count with no added cycle of delay.
- R10: A 2-bit instance that is reset and then enabled in the up direction shows 1, 2, 3, 3, 3 after the successive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, never gated |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| cnt_en | input | 1 | Count enable; when 0 the count holds |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down |
| count | output | WIDTH | Current count value (default WIDTH = 3) |
| at_max | output | 1 | High while count is all ones |
| at_min | output | 1 | High while count is zero |

## Verification
The bench builds two instances that share one stimulus: one at the default width of 3 and one at width 2. The 3-bit instance walks its whole range, from zero through every value to all-ones and back again. This reaches both saturation points, the reversals away from them, and holds with enable low at interior points and at the limits. The 2-bit instance gives the short up-only run, in which the hold at all-ones appears after only three steps. Reset is also asserted in the middle of enabled counting, to show that it wins over a step.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Step decision passed from the control logic to the register.
  typedef struct packed {
    logic inc;
    logic dec;
  } step_t;

  localparam step_t STEP_NONE = '{inc: 1'b0, dec: 1'b0};

endpackage

// File: rtl/sat_limit_detect.sv
module sat_limit_detect #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_full,
  output logic             is_empty
);

  localparam logic [WIDTH-1:0] FULL_VAL  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] EMPTY_VAL = '0;

  function automatic logic fn_match(input logic [WIDTH-1:0] v,
                                    input logic [WIDTH-1:0] ref_v);
    return (v == ref_v);
  endfunction

  assign is_full  = fn_match(value, FULL_VAL);
  assign is_empty = fn_match(value, EMPTY_VAL);

endmodule

// File: rtl/sat_step_ctrl.sv
module sat_step_ctrl
  import sat_cnt_pkg::*;
(
  input  logic  cnt_en,
  input  logic  dir_up,
  input  logic  lim_full,
  input  logic  lim_empty,
  output step_t step,
  output logic  blocked
);

  dir_e dir;
  logic up_ok;
  logic down_ok;

  // A step is refused only in the direction that points past the limit.
  function automatic step_t fn_decide(input logic en, input dir_e d,
                                      input logic uok, input logic dok);
    step_t s;
    s = STEP_NONE;
    if (en) begin
      if (d == DIR_UP) s.inc = uok;
      else             s.dec = dok;
    end
    return s;
  endfunction

  assign dir     = dir_e'(dir_up);
  assign up_ok   = !lim_full;
  assign down_ok = !lim_empty;
  assign step    = fn_decide(cnt_en, dir, up_ok, down_ok);
  assign blocked = cnt_en && !step.inc && !step.dec;

endmodule

// File: rtl/sat_count_reg.sv
module sat_count_reg
  import sat_cnt_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  step_t            step,
  output logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] value_nxt;

  function automatic logic [WIDTH-1:0] fn_apply(input logic [WIDTH-1:0] v,
                                                input step_t s);
    if (s.inc)      return v + ONE;
    else if (s.dec) return v - ONE;
    else            return v;
  endfunction

  assign value_nxt = fn_apply(value, step);

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= value_nxt;
  end

  // R1: leaving reset the register holds zero
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (value == '0));

  // R3: an up decision adds exactly one
  p_inc_one_r3: assert property (@(posedge clk) disable iff (rst)
    step.inc |=> (value == $past(value) + ONE));

  // R4: a down decision subtracts exactly one
  p_dec_one_r4: assert property (@(posedge clk) disable iff (rst)
    step.dec |=> (value == $past(value) - ONE));

  // R2: no decision, no change
  p_no_step_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!step.inc && !step.dec) |=> $stable(value));

endmodule

// File: rtl/sat_updown_counter.sv
module sat_updown_counter
  import sat_cnt_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             dir_up,
  output logic [WIDTH-1:0] count,
  output logic             at_max,
  output logic             at_min
);

  step_t step;
  logic  step_blocked;

  sat_limit_detect #(.WIDTH(WIDTH)) u_detect (
    .value    (count),
    .is_full  (at_max),
    .is_empty (at_min)
  );

  sat_step_ctrl u_ctrl (
    .cnt_en    (cnt_en),
    .dir_up    (dir_up),
    .lim_full  (at_max),
    .lim_empty (at_min),
    .step      (step),
    .blocked   (step_blocked)
  );

  sat_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .value (count)
  );

  // R2: enable low freezes the count
  p_en_low_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  // R5: saturation at the top
  p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_up && at_max) |=> at_max);

  // R6: saturation at the bottom
  p_sat_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && at_min) |=> at_min);

  // R7: reversal away from the top
  p_leave_top_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && at_max) |=> !at_max);

  // R8: reversal away from the bottom
  p_leave_bottom_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_up && at_min) |=> !at_min);

  // R9: limit flags never both set, and a blocked step only happens at a limit
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(at_max && at_min) || (WIDTH == 0));

  p_block_at_limit_r9: assert property (@(posedge clk) disable iff (rst)
    step_blocked |-> (at_max || at_min));

  p_step_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step.inc, step.dec}));

endmodule

// File: tb/test_sat_updown_counter.sv
`timescale 1ns/1ps
module test_sat_updown_counter;

  localparam int W3 = 3;
  localparam int W2 = 2;
  localparam int MAX3 = (1 << W3) - 1;
  localparam int VEC_N = 20;
  localparam int WD_CYCLES = 200000;

  // each entry: {cnt_en, dir_up}
  localparam logic [1:0] VEC_IN [VEC_N] = '{
    2'b11, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11,
    2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11
  };
  localparam logic [2:0] VEC_EXP [VEC_N] = '{
    3'd1, 3'd2, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd7, 3'd7,
    3'd6, 3'd5, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0, 3'd1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic dir_up = 1'b0;
  logic [W3-1:0] count3;
  logic at_max3, at_min3;
  logic [W2-1:0] count2;
  logic at_max2, at_min2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sat_updown_counter #(.WIDTH(W3)) i_sat_updown_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up),
    .count(count3), .at_max(at_max3), .at_min(at_min3)
  );

  sat_updown_counter #(.WIDTH(W2)) i_sat_updown_counter_w2 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up),
    .count(count2), .at_max(at_max2), .at_min(at_min2)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive on the falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic en, input logic up, input logic r);
    @(negedge clk);
    cnt_en = en;
    dir_up = up;
    rst = r;
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic en, input logic up, input int prev);
    if (!en)                   return "R2";
    if (up && prev == MAX3)    return "R5";
    if (!up && prev == 0)      return "R6";
    if (!up && prev == MAX3)   return "R7";
    if (up && prev == 0)       return "R8";
    if (up)                    return "R3";
    return "R4";
  endfunction

  initial begin
    #(WD_CYCLES * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int prev;
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    // R1: reset state and flags
    chk("R1 count", int'(count3), 0);
    chk("R1 at_min", int'(at_min3), 1);
    chk("R1 at_max", int'(at_max3), 0);

    // vector walk over the 3-bit range
    prev = 0;
    for (int i = 0; i < VEC_N; i++) begin
      step(VEC_IN[i][1], VEC_IN[i][0], 1'b0);
      chk(tag_of(VEC_IN[i][1], VEC_IN[i][0], prev), int'(count3), int'(VEC_EXP[i]));
      chk("R9 at_max", int'(at_max3), (int'(VEC_EXP[i]) == MAX3) ? 1 : 0);
      chk("R9 at_min", int'(at_min3), (int'(VEC_EXP[i]) == 0) ? 1 : 0);
      prev = int'(VEC_EXP[i]);
    end

    // R1: reset beats an enabled up step
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk("R3 pre-reset count", int'(count3), 3);
    step(1'b1, 1'b1, 1'b1);
    chk("R1 reset over enable", int'(count3), 0);
    chk("R1 reset over enable w2", int'(count2), 0);

    // R10: 2-bit up-only run, 1,2,3,3,3
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 1'b1, 1'b0);
      chk("R10 w2 sequence", int'(count2), (k < 3) ? k + 1 : 3);
    end
    chk("R9 w2 at_max", int'(at_max2), 1);

    // R2: enable low at the top limit with direction down holds
    step(1'b0, 1'b0, 1'b0);
    chk("R2 w2 hold at max", int'(count2), 3);
    // R7 on the 2-bit instance
    step(1'b1, 1'b0, 1'b0);
    chk("R7 w2 leave max", int'(count2), 2);

    // R2 at zero with direction up and enable low
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    chk("R2 hold at min", int'(count3), 0);
    chk("R9 at_min after hold", int'(at_min3), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule